// File: doc/BRIEF.md
# One-Shot Pulse Timer Channel

An up-counting timer with a single compare channel. The counter is started either by a one-cycle software set strobe or by a rising edge on an external trigger input. Once started, it steps from its current value up to a programmable auto-reload limit. On reaching the limit it raises a one-cycle update pulse and returns to zero. In repetitive mode it keeps running after the update. In single-pulse mode the update also drops the run flag, so each start yields exactly one period.

The compare channel turns the count into a reference waveform. It can hold its level, toggle on a compare hit, or produce one of two complementary PWM levels. Compare results reach the output through a two-stage pipeline. For trigger-started single pulses in a PWM mode, an optional fast path bypasses that pipeline. The output then jumps to its post-match level on the same edge that starts the counter, and stays there until the update.

Top module: `oneshot_pulse_timer`

## Requirements
- R1: After reset, `count` is 0, and `running`, `update` and `ref_out` are all 0.
- R2: A start (`sw_en_set` high for one cycle, or an accepted trigger edge) raises `running` on the next edge with `count` unchanged. While running, `count` rises by one on every edge.
- R3: `update` is high for exactly the cycles in which `running` is 1, `sw_en_clr` is 0 and `count` equals `arr_val`. On the next edge `count` becomes 0. In repetitive mode (`single_mode` = 0), counting continues.
- R4: In single-pulse mode (`single_mode` = 1), the edge that ends an update cycle also clears `running`, and the counter then stays at 0.
- R5: `sw_en_clr` has priority over every start. It clears `running` on the next edge and leaves `count` at its value, and a later start resumes counting from that value.
- R6: `trig_in` passes through two synchronising flops. A 0-to-1 change sampled on edge k starts the counter on edge k+2, provided `trig_en` = 1. Trigger edges are ignored while `trig_en` = 0 or while the counter runs. `sw_en_set` while running has no effect.
- R7: `chan_mode` = 2'b10 gives `ref_out` = 1 when the count is below `cmp_val`. `chan_mode` = 2'b11 gives `ref_out` = 1 when the count is at or above `cmp_val`. `ref_out` reflects the count value two edges earlier.
- R8: `chan_mode` = 2'b01 inverts `ref_out` two edges after a running count equal to `cmp_val`. `chan_mode` = 2'b00 holds `ref_out` unchanged.
- R9: With `fast_en` = 1, `single_mode` = 1 and a PWM mode, a trigger-edge start sets `ref_out` on the same edge as `running` to its post-match level (0 for 2'b10, 1 for 2'b11). It keeps that level until the update cycle; afterwards the normal two-edge lag resumes.
- R10: `fast_en` has no effect when the start comes from `sw_en_set`, in repetitive mode, or in modes 2'b00 and 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| single_mode | input | 1 | 1 = single pulse, 0 = repetitive |
| sw_en_set | input | 1 | Software start strobe |
| sw_en_clr | input | 1 | Software stop strobe (holds count) |
| trig_en | input | 1 | Accept starts from the trigger input |
| trig_in | input | 1 | Asynchronous external trigger |
| arr_val | input | CNT_W | Auto-reload limit |
| cmp_val | input | CNT_W | Compare value |
| chan_mode | input | 2 | 00 hold, 01 toggle, 10 PWM low-side, 11 PWM high-side |
| fast_en | input | 1 | Fast trigger-to-output option |
| count | output | CNT_W | Counter value |
| running | output | 1 | Counter enable state |
| update | output | 1 | One-cycle update event |
| ref_out | output | 1 | Channel reference output |

## Verification
The bench builds the block with its default 16-bit counter and two synchroniser stages. Because limit and compare values are inputs, it can run short periods: limits of 0, 5 and 9 exercise wrap, single stop and the zero-length period. It also runs a full limit of 99 with compare 4. These short runs bring every cycle of the two-edge compare lag, and the exact point where the fast path hands back to the pipeline, within a few dozen cycles.

// File: rtl/opt_pkg.sv
`timescale 1ns/1ps
package opt_pkg;

    typedef enum logic [1:0] {
        CH_FROZEN = 2'b00,
        CH_TOGGLE = 2'b01,
        CH_PWM_LO = 2'b10,
        CH_PWM_HI = 2'b11
    } ch_mode_e;

    typedef struct packed {
        logic lvl;
        logic hit;
    } cmp_stage_t;

    function automatic logic is_pwm(ch_mode_e m);
        return m[1];
    endfunction

    // level of a PWM reference given whether the match point has been passed
    function automatic logic pwm_level(ch_mode_e m, logic passed);
        return (m == CH_PWM_HI) ? passed : ~passed;
    endfunction

endpackage

// File: rtl/opt_trig_sync.sv
`timescale 1ns/1ps
module opt_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_in,
    output logic rise_o
);
    logic [STAGES:0] sr;

    always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-1:0], trig_in};
    end

    assign rise_o = sr[STAGES-1] & ~sr[STAGES];
endmodule

// File: rtl/opt_count_core.sv
`timescale 1ns/1ps
module opt_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_set,
    input  logic             sw_clr,
    input  logic             single_mode,
    input  logic             trig_rise,
    input  logic             trig_en,
    input  logic [CNT_W-1:0] arr,
    output logic [CNT_W-1:0] cnt,
    output logic             run,
    output logic             upd,
    output logic             adv,
    output logic             trig_start
);
    assign adv        = run & ~sw_clr;
    assign upd        = adv && (cnt == arr);
    assign trig_start = trig_rise & trig_en & ~run & ~sw_clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            run <= 1'b0;
        end else begin
            if (sw_clr)
                run <= 1'b0;
            else if (!run && (sw_set || trig_start))
                run <= 1'b1;
            else if (upd && single_mode)
                run <= 1'b0;
            if (adv)
                cnt <= upd ? '0 : cnt + 1'b1;
        end
    end

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        adv && !upd |=> cnt == $past(cnt) + 1'b1);

    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        upd && !single_mode |=> cnt == '0 && run);

    p_single_stop_r4: assert property (@(posedge clk) disable iff (rst)
        upd && single_mode |=> cnt == '0 && !run);

    p_clr_hold_r5: assert property (@(posedge clk) disable iff (rst)
        sw_clr |=> !run && $stable(cnt));
endmodule

// File: rtl/opt_cmp_chan.sv
`timescale 1ns/1ps
module opt_cmp_chan
    import opt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  ch_mode_e         mode,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic             adv,
    input  logic             upd,
    input  logic             fast_fire,
    output logic             ref_o
);
    logic       hold;
    cmp_stage_t st, st_nxt;
    logic       post_lvl;

    always_comb begin
        st_nxt.lvl = pwm_level(mode, (cnt >= cmp) | hold);
        st_nxt.hit = adv && (cnt == cmp);
        post_lvl   = pwm_level(mode, 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold  <= 1'b0;
            st    <= '0;
            ref_o <= 1'b0;
        end else begin
            if (fast_fire)  hold <= 1'b1;
            else if (upd)   hold <= 1'b0;

            if (fast_fire) begin
                st.lvl <= post_lvl;
                st.hit <= 1'b0;
                ref_o  <= post_lvl;
            end else begin
                st <= st_nxt;
                case (mode)
                    CH_FROZEN: ref_o <= ref_o;
                    CH_TOGGLE: ref_o <= ref_o ^ st.hit;
                    default:   ref_o <= st.lvl;
                endcase
            end
        end
    end

    p_fast_hi_r9: assert property (@(posedge clk) disable iff (rst)
        fast_fire && mode == CH_PWM_HI |=> ref_o);

    p_fast_lo_r9: assert property (@(posedge clk) disable iff (rst)
        fast_fire && mode == CH_PWM_LO |=> !ref_o);

    p_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        !fast_fire && mode == CH_FROZEN |=> $stable(ref_o));
endmodule

// File: rtl/oneshot_pulse_timer.sv
`timescale 1ns/1ps
module oneshot_pulse_timer
    import opt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             single_mode,
    input  logic             sw_en_set,
    input  logic             sw_en_clr,
    input  logic             trig_en,
    input  logic             trig_in,
    input  logic [CNT_W-1:0] arr_val,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic [1:0]       chan_mode,
    input  logic             fast_en,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             update,
    output logic             ref_out
);
    ch_mode_e mode;
    logic     trig_rise, adv, trig_start, fast_fire;

    assign mode = ch_mode_e'(chan_mode);

    opt_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .trig_in(trig_in),
        .rise_o (trig_rise)
    );

    opt_count_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .sw_set     (sw_en_set),
        .sw_clr     (sw_en_clr),
        .single_mode(single_mode),
        .trig_rise  (trig_rise),
        .trig_en    (trig_en),
        .arr        (arr_val),
        .cnt        (count),
        .run        (running),
        .upd        (update),
        .adv        (adv),
        .trig_start (trig_start)
    );

    // fast path only for trigger starts of a single PWM pulse
    assign fast_fire = trig_start & fast_en & single_mode & is_pwm(mode);

    opt_cmp_chan #(.CNT_W(CNT_W)) u_chan (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .cnt      (count),
        .cmp      (cmp_val),
        .adv      (adv),
        .upd      (update),
        .fast_fire(fast_fire),
        .ref_o    (ref_out)
    );

    p_no_trig_restart_r6: assert property (@(posedge clk) disable iff (rst)
        running && !sw_en_clr && !update |=> running);
endmodule

// File: tb/oneshot_pulse_timer_tb.sv
`timescale 1ns/1ps
module oneshot_pulse_timer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        single_mode = 1'b0, sw_en_set = 1'b0, sw_en_clr = 1'b0;
    logic        trig_en = 1'b0, trig_in = 1'b0, fast_en = 1'b0;
    logic [15:0] arr_val = '0, cmp_val = '0;
    logic [1:0]  chan_mode = 2'b00;
    logic [15:0] count;
    logic        running, update, ref_out;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    oneshot_pulse_timer u_dut (
        .clk(clk), .rst(rst), .single_mode(single_mode), .sw_en_set(sw_en_set),
        .sw_en_clr(sw_en_clr), .trig_en(trig_en), .trig_in(trig_in),
        .arr_val(arr_val), .cmp_val(cmp_val), .chan_mode(chan_mode),
        .fast_en(fast_en), .count(count), .running(running),
        .update(update), .ref_out(ref_out)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit lvl(logic [1:0] md, int c, int cmp);
        return (md == 2'b11) ? (c >= cmp) : (c < cmp);
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        single_mode = 0; sw_en_set = 0; sw_en_clr = 0; trig_en = 0;
        trig_in = 0; fast_en = 0; arr_val = '0; cmp_val = '0; chan_mode = 2'b00;
        repeat (3) step();
        rst = 1'b0;
        repeat (3) step();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 count", count, 0);
        chk("R1 running", running, 0);
        chk("R1 update", update, 0);
        chk("R1 ref_out", ref_out, 0);
    endtask

    // start the counter and follow count, running, update and ref_out per cycle
    task automatic track(string tag, bit by_trig, bit fe, bit sm,
                         logic [1:0] md, int a, int c, int n);
        int h1 = 0, h2 = 0;
        bit eff = by_trig && fe && sm && md[1];
        bit post = (md == 2'b11);
        do_reset();
        arr_val = 16'(a); cmp_val = 16'(c); single_mode = sm;
        chan_mode = md; fast_en = fe; trig_en = 1'b1;
        repeat (3) step();
        if (by_trig) begin
            trig_in = 1'b1;
            step(); chk({tag, " R6 sync edge1"}, running, 0);
            step(); chk({tag, " R6 sync edge2"}, running, 0);
            step();
            trig_in = 1'b0;
        end else begin
            sw_en_set = 1'b1;
            step();
            sw_en_set = 1'b0;
        end
        for (int i = 0; i < n; i++) begin
            int  ec = sm ? ((i <= a) ? i : 0) : (i % (a + 1));
            bit  er = sm ? (i <= a) : 1'b1;
            bit  eu = er && (ec == a);
            bit  eref = (eff && i <= a + 2) ? post : lvl(md, h2, c);
            chk({tag, " R2 count"}, count, ec);
            chk({tag, " R4 running"}, running, er);
            chk({tag, " R3 update"}, update, eu);
            chk({tag, " R7 ref_out"}, ref_out, eref);
            h2 = h1; h1 = ec;
            step();
        end
    endtask

    task automatic t_toggle_frozen();
        bit cur = 1'b0, hh1 = 1'b0, hh2 = 1'b0, held;
        do_reset();
        arr_val = 16'd5; cmp_val = 16'd2; chan_mode = 2'b01;
        fast_en = 1'b1; single_mode = 1'b0; trig_en = 1'b1;
        repeat (3) step();
        trig_in = 1'b1;
        repeat (3) step();
        trig_in = 1'b0;
        chk("R10 fast ignored in toggle mode", ref_out, 0);
        for (int i = 0; i < 18; i++) begin
            int ec = i % 6;
            cur = cur ^ hh2;
            chk("R8 toggle ref_out", ref_out, cur);
            hh2 = hh1; hh1 = (ec == 2);
            step();
        end
        chan_mode = 2'b00;
        step();
        held = ref_out;
        for (int i = 0; i < 8; i++) begin
            step();
            chk("R8 frozen ref_out", ref_out, held);
        end
    endtask

    task automatic t_clear_hold();
        do_reset();
        arr_val = 16'd20; single_mode = 1'b1;
        sw_en_set = 1'b1; step(); sw_en_set = 1'b0;
        repeat (6) step();
        chk("R5 before clear", count, 6);
        sw_en_clr = 1'b1; step(); sw_en_clr = 1'b0;
        chk("R5 running after clear", running, 0);
        chk("R5 count held", count, 6);
        repeat (3) step();
        chk("R5 count still held", count, 6);
        sw_en_set = 1'b1; sw_en_clr = 1'b1; step(); sw_en_set = 1'b0; sw_en_clr = 1'b0;
        chk("R5 clear beats set", running, 0);
        sw_en_set = 1'b1; step(); sw_en_set = 1'b0;
        chk("R5 restart running", running, 1);
        chk("R5 restart count", count, 6);
        step();
        chk("R5 resume count", count, 7);
    endtask

    task automatic t_ignored();
        do_reset();
        arr_val = 16'd50; single_mode = 1'b1; trig_en = 1'b0;
        trig_in = 1'b1;
        repeat (5) step();
        chk("R6 trig_en=0 running", running, 0);
        chk("R6 trig_en=0 count", count, 0);
        trig_in = 1'b0;
        repeat (2) step();
        trig_en = 1'b1;
        sw_en_set = 1'b1; step(); sw_en_set = 1'b0;
        repeat (2) step();
        chk("R2 count after sw start", count, 2);
        trig_in = 1'b1;
        repeat (5) step();
        chk("R6 trig while running count", count, 7);
        chk("R6 trig while running running", running, 1);
        trig_in = 1'b0;
        sw_en_set = 1'b1; step(); sw_en_set = 1'b0;
        chk("R6 set while running", count, 8);
    endtask

    initial begin
        t_reset();
        track("rep PWM0",       0, 0, 0, 2'b10, 5, 2, 20);
        track("single PWM1",    0, 0, 1, 2'b11, 9, 4, 16);
        track("zero limit",     0, 0, 1, 2'b11, 0, 0, 6);
        track("trig no fast",   1, 0, 1, 2'b11, 9, 4, 16);
        track("R9 fast PWM1",   1, 1, 1, 2'b11, 9, 4, 16);
        track("R9 fast PWM0",   1, 1, 1, 2'b10, 9, 4, 16);
        track("R10 fast sw",    0, 1, 1, 2'b11, 9, 4, 16);
        track("R10 fast rep",   1, 1, 0, 2'b11, 5, 2, 14);
        track("R9 limit 99",    1, 1, 1, 2'b11, 99, 4, 106);
        t_toggle_frozen();
        t_clear_hold();
        t_ignored();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule